// File: doc/BRIEF.md
# Reloadable Timer and Watchdog Counter

The block is a 16-bit down-counter stepped by an 8-bit prescaler. It runs either as a general timer/counter or as a watchdog. The prescaler is fed from one of two sources: the system clock divided by four, or falling edges on an external input that first pass through a synchronizer. Software reaches the block through a byte-wide write port and a combinational read port. Through these it loads the prescaler constant and the counter constant, sets the control bits, clears the interrupt flag and refreshes the watchdog. The read port also returns the live count.

Write addresses are: 0 control, 1 prescaler constant, 2 counter constant low byte, 3 counter constant high byte, 4 status, 5 watchdog refresh (any data). The control byte uses bit 0 for run, bit 1 for continuous (0 = single), bit 2 for external input, and bit 3 for watchdog. Read addresses are: 0 control byte, 1 prescaler constant, 2 and 3 the live count low and high byte, 4 status with the flag in bit 0.

A state machine with three states sets when the counter moves:
- ST_STOP holds the count. It leaves through "start" (control write with bit 0 set) to ST_RUN.
- ST_RUN counts. It leaves through "stop" (control write with bit 0 clear) or "single end" (end of count in single mode) back to ST_STOP.
- ST_WDOG is entered through "force" from any state while the watchdog bit or the force pin is set. It leaves through "release" only when the pin drops and the bit was never set. It then goes to ST_RUN or ST_STOP, following the run bit.

Top module: `tw_timer_wdog`

## Requirements
- R1: After reset the control byte reads 00h, the prescaler constant reads FFh, the count reads FFFFh, and irq, sq_out and wd_rst are low. A start without programming counts down from these values: the first step comes 1024 clocks after the start.
- R2: With the internal source, the time between end-of-count events is 4 × (P+1) × (C+1) clocks. P is the prescaler constant and C is the counter constant. P=0 and C=0 give 4 clocks.
- R3: In continuous mode (control bit 1 = 1), end of count reloads C, and counting goes on with equal periods.
- R4: In single mode (control bit 1 = 0), end of count reloads C, clears control bit 0 and stops the counter.
- R5: Clearing control bit 0 freezes the count. Setting it again resumes from the frozen count, with one step per 4 clocks at P=0.
- R6: A counter constant written while stopped is loaded into the count at the next start.
- R7: A counter constant written while running leaves the current count untouched. It is loaded at the next end of count.
- R8: A prescaler constant written while running takes effect immediately, without waiting for the old prescaler value to run out.
- R9: With control bit 2 set, the prescaler steps only on falling edges of ext_in; the system clock does not step it. With P=0 and C=2, the third falling edge gives end of count and the second does not.
- R10: In timer operation, each end of count toggles sq_out and sets the status flag, which drives irq. Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it set.
- R11: The watchdog is active while control bit 3 or wd_force is set. While it is active, control bit 0 has no effect and the counter always runs. Once set, bit 3 can be cleared only by reset.
- R12: In watchdog operation, a write to address 5 reloads the prescaler and the count. End of count gives a wd_rst pulse exactly one clock wide and leaves irq and sq_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ext_in | input | 1 | External event input, asynchronous |
| wd_force | input | 1 | Forces watchdog operation while high |
| irq | output | 1 | End-of-count interrupt flag |
| sq_out | output | 1 | Square wave, toggles at each timer end of count |
| wd_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler and a divide-by-four internal source. It then programs small constants, so that periods of 4 to a few hundred clocks fall inside short runs. The reset constants are covered by timing a single step at prescaler FFh, which takes 1024 clocks. A full FFFFh count is left unrun. Stop and resume is checked against an exact count, because the divider phase is held across a stop.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_WDOG = 2'd2
    } tw_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_PRE  = 3'd1;
    localparam logic [2:0] A_CLO  = 3'd2;
    localparam logic [2:0] A_CHI  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_KICK = 3'd5;
endpackage

// File: rtl/tw_tick_src.sv
// Source of prescaler steps: internal clock divider or synchronized falling edge.
module tw_tick_src #(
    parameter int DIV_LOG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_mode,
    input  logic clr,
    input  logic ext_in,
    output logic tick
);
    logic [DIV_LOG-1:0] div_q;
    logic s1_q, s2_q, s3_q;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall = s3_q & ~s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr)
            div_q <= '0;
        else if (run && !ext_mode)
            div_q <= div_q + 1'b1;
    end

    assign tick = run & ~clr & (ext_mode ? fall : (div_q == '1));
endmodule

// File: rtl/tw_prescaler.sv
// Reloading prescaler: one output step per (value+1) input steps.
module tw_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PRE_W-1:0] value,
    output logic             ptick
);
    logic [PRE_W-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '1;
        else if (load)
            pcnt_q <= value;
        else if (tick)
            pcnt_q <= (pcnt_q == '0) ? value : pcnt_q - 1'b1;
    end

    assign ptick = tick & ~load & (pcnt_q == '0);
endmodule

// File: rtl/tw_timer_wdog.sv
module tw_timer_wdog #(
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 8,
    parameter int DIV_LOG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       ext_in,
    input  logic       wd_force,
    output logic       irq,
    output logic       sq_out,
    output logic       wd_rst
);
    import tw_pkg::*;

    localparam int HI_W = CNT_W - 8;

    tw_state_e        state_q, nxt;
    logic             st_sp_q, cont_q, in_en_q, wd_en_q, dirty_q, flag_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnst_q, cnt_q;
    logic             wr_ctrl, wr_pre, wr_const, wr_stat, wr_kick;
    logic             running, src_tick, ptick, eoc, wd_act, kick, start_go;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_pre   = wr_en && (wr_addr == A_PRE);
    assign wr_const = wr_en && ((wr_addr == A_CLO) || (wr_addr == A_CHI));
    assign wr_stat  = wr_en && (wr_addr == A_STAT);
    assign wr_kick  = wr_en && (wr_addr == A_KICK);
    assign wd_act   = wd_en_q | wd_force;
    assign running  = (state_q != ST_STOP);
    assign kick     = wr_kick && (state_q == ST_WDOG);
    assign eoc      = running && ptick && (cnt_q == '0);
    assign start_go = (state_q == ST_STOP) && (nxt == ST_RUN);

    tw_tick_src #(.DIV_LOG(DIV_LOG)) u_src (
        .clk(clk), .rst_n(rst_n), .run(running), .ext_mode(in_en_q),
        .clr(kick), .ext_in(ext_in), .tick(src_tick)
    );

    tw_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(src_tick), .load(wr_pre | kick),
        .value(wr_pre ? wr_data[PRE_W-1:0] : pre_q), .ptick(ptick)
    );

    // Control and constant registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_sp_q <= 1'b0;
            cont_q  <= 1'b0;
            in_en_q <= 1'b0;
            wd_en_q <= 1'b0;
            pre_q   <= '1;
            cnst_q  <= '1;
            dirty_q <= 1'b0;
        end else begin
            if (eoc && (state_q == ST_RUN) && !cont_q)
                st_sp_q <= 1'b0;
            if (wr_ctrl) begin
                st_sp_q <= wr_data[0];
                cont_q  <= wr_data[1];
                in_en_q <= wr_data[2];
                wd_en_q <= wd_en_q | wr_data[3];
            end
            if (wr_pre)
                pre_q <= wr_data[PRE_W-1:0];
            if (wr_en && (wr_addr == A_CLO))
                cnst_q[7:0] <= wr_data;
            if (wr_en && (wr_addr == A_CHI))
                cnst_q[CNT_W-1:8] <= wr_data[HI_W-1:0];
            if (wr_const && (state_q == ST_STOP))
                dirty_q <= 1'b1;
            else if (start_go)
                dirty_q <= 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else
            state_q <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state_q;
        if (wd_act) begin
            nxt = ST_WDOG;                                   // force
        end else begin
            unique case (state_q)
                ST_STOP: if (wr_ctrl && wr_data[0]) nxt = ST_RUN;  // start
                ST_RUN: begin
                    if (wr_ctrl)
                        nxt = wr_data[0] ? ST_RUN : ST_STOP;   // stop
                    else if (eoc && !cont_q)
                        nxt = ST_STOP;                         // single end
                end
                ST_WDOG: nxt = st_sp_q ? ST_RUN : ST_STOP;     // release
                default: nxt = ST_STOP;
            endcase
        end
    end

    // Counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (kick)
            cnt_q <= cnst_q;
        else if (start_go && dirty_q)
            cnt_q <= cnst_q;
        else if (running && ptick)
            cnt_q <= (cnt_q == '0) ? cnst_q : cnt_q - 1'b1;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            sq_out <= 1'b0;
            wd_rst <= 1'b0;
        end else begin
            wd_rst <= eoc && (state_q == ST_WDOG);
            if (eoc && (state_q == ST_RUN)) begin
                flag_q <= 1'b1;
                sq_out <= ~sq_out;
            end else if (wr_stat && wr_data[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign irq = flag_q;

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = {4'b0, wd_en_q, in_en_q, cont_q, st_sp_q};
            A_PRE:   rd_data = 8'(pre_q);
            A_CLO:   rd_data = cnt_q[7:0];
            A_CHI:   rd_data = 8'(cnt_q >> 8);
            A_STAT:  rd_data = {7'b0, flag_q};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/tw_chk.sv
module tw_chk (
    input logic              clk,
    input logic              rst_n,
    input tw_pkg::tw_state_e state_q,
    input logic              eoc,
    input logic              cont_q,
    input logic              wd_en_q,
    input logic              wr_ctrl,
    input logic              wr_const,
    input logic              ptick,
    input logic [15:0]       cnt_lo16,
    input logic              sq_out,
    input logic              irq,
    input logic              wd_rst
);
    import tw_pkg::*;

    assert_wdrst_one_clk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> !wd_rst);

    assert_wdog_no_toggle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDOG) |=> $stable(sq_out));

    assert_toggle_sets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_out != $past(sq_out)) |-> irq);

    assert_single_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && state_q == ST_RUN && !cont_q && !wr_ctrl) |=> (state_q == ST_STOP));

    assert_wd_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wd_en_q) |-> wd_en_q);

    assert_run_const_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wr_const && !ptick) |=> $stable(cnt_lo16));
endmodule

bind tw_timer_wdog tw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .eoc(eoc), .cont_q(cont_q),
    .wd_en_q(wd_en_q), .wr_ctrl(wr_ctrl), .wr_const(wr_const), .ptick(ptick),
    .cnt_lo16(16'(cnt_q)), .sq_out(sq_out), .irq(irq), .wd_rst(wd_rst)
);

// File: tb/tw_timer_wdog_tb_top.sv
module tw_timer_wdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       ext_in = 1'b1;
    logic       wd_force = 1'b0;
    logic       irq, sq_out, wd_rst;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    tw_timer_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_in(ext_in), .wd_force(wd_force), .irq(irq), .sq_out(sq_out),
        .wd_rst(wd_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(3'd2, lo);
        rd(3'd3, hi);
        v = hi * 256 + lo;
    endtask

    task automatic set_const(input int c);
        wr(3'd3, 8'(c >> 8));
        wr(3'd2, 8'(c));
    endtask

    // negedges until sq_out changes; returns limit+1 on timeout
    task automatic wait_toggle(input int limit, output int n);
        logic s0;
        s0 = sq_out;
        n = 0;
        while (sq_out == s0 && n <= limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        int v;
        rd(3'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
        rd(3'd1, v); chk(v == 255, "R1 prescaler reset", v, 255);
        rd_cnt(v);   chk(v == 65535, "R1 count reset", v, 65535);
        chk(irq == 0 && sq_out == 0 && wd_rst == 0, "R1 outputs low",
            int'({irq, sq_out, wd_rst}), 0);
    endtask

    task automatic t_defaults();
        int v;
        wr(3'd0, 8'h01);
        repeat (1020) @(negedge clk);
        rd_cnt(v); chk(v == 65535, "R1 no step before 1024", v, 65535);
        repeat (8) @(negedge clk);
        rd_cnt(v); chk(v == 65534, "R1 one step after 1024", v, 65534);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_period(input int p, input int c);
        int n;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'(p));
        set_const(c);
        wr(3'd0, 8'h03);
        wait_toggle(10000, n);
        wait_toggle(10000, n);
        chk(n == 4 * (p + 1) * (c + 1), "R2 period", n, 4 * (p + 1) * (c + 1));
        wait_toggle(10000, n);
        chk(n == 4 * (p + 1) * (c + 1), "R3 continuous repeat", n, 4 * (p + 1) * (c + 1));
        wr(3'd0, 8'h00);
    endtask

    task automatic t_single();
        int n, v;
        logic s;
        wr(3'd1, 8'h00);
        set_const(5);
        wr(3'd0, 8'h01);
        wait_toggle(100, n);
        chk(n <= 30, "R4 single end reached", n, 24);
        rd(3'd0, v); chk((v & 1) == 0, "R4 run bit cleared", v & 1, 0);
        rd_cnt(v);   chk(v == 5, "R4 reloaded", v, 5);
        s = sq_out;
        repeat (40) @(negedge clk);
        rd_cnt(v);   chk(v == 5 && sq_out == s, "R4 stays stopped", v, 5);
    endtask

    task automatic t_stop_resume();
        int a, b, d;
        wr(3'd1, 8'h00);
        set_const(100);
        wr(3'd0, 8'h03);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h02);
        rd_cnt(a);
        repeat (50) @(negedge clk);
        rd_cnt(b); chk(b == a, "R5 frozen", b, a);
        wr(3'd0, 8'h03);
        repeat (12) @(negedge clk);
        rd_cnt(d); chk(d == a - 3, "R5 resumed from held", d, a - 3);
        wr(3'd0, 8'h02);
        set_const(7);
        wr(3'd0, 8'h03);
        rd_cnt(d); chk(d == 7, "R6 load at start", d, 7);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_const_running();
        int v, n;
        wr(3'd1, 8'h00);
        set_const(20);
        wr(3'd0, 8'h03);
        repeat (8) @(negedge clk);
        set_const(3);
        rd_cnt(v); chk(v > 3 && v <= 20, "R7 count undisturbed", v, 17);
        wait_toggle(200, n);
        wait_toggle(200, n);
        chk(n == 16, "R7 new constant after end", n, 16);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_pre_now();
        int n;
        wr(3'd1, 8'd50);
        set_const(0);
        wr(3'd0, 8'h03);
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h00);
        wait_toggle(300, n);
        chk(n <= 8, "R8 prescaler immediate", n, 4);
        wr(3'd0, 8'h00);
    endtask

    task automatic fall_edge();
        @(negedge clk); ext_in = 1'b0;
        repeat (5) @(negedge clk);
        ext_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_event();
        logic s;
        wr(3'd1, 8'h00);
        set_const(2);
        s = sq_out;
        wr(3'd0, 8'h07);
        repeat (100) @(negedge clk);
        chk(sq_out == s, "R9 internal clock ignored", int'(sq_out), int'(s));
        fall_edge();
        fall_edge();
        chk(sq_out == s, "R9 no end after two edges", int'(sq_out), int'(s));
        fall_edge();
        chk(sq_out != s, "R9 end after third edge", int'(sq_out), int'(!s));
        wr(3'd0, 8'h00);
    endtask

    task automatic t_irq();
        chk(irq == 1, "R10 flag set by end", int'(irq), 1);
        wr(3'd4, 8'h00);
        chk(irq == 1, "R10 write 0 keeps flag", int'(irq), 1);
        wr(3'd4, 8'h01);
        chk(irq == 0, "R10 write 1 clears", int'(irq), 0);
    endtask

    task automatic wait_wdrst(input int limit, output int n, output int w);
        n = 0;
        w = 0;
        while (!wd_rst && n <= limit) begin
            @(negedge clk);
            n++;
        end
        while (wd_rst && w < 10) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic t_wdog_bit();
        int n, w, v, seen;
        logic s;
        do_reset();
        wr(3'd1, 8'h00);
        set_const(9);
        wr(3'd0, 8'h08);
        wr(3'd5, 8'h00);
        s = sq_out;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                if (wd_rst) seen++;
            end
            wr(3'd5, 8'h00);
        end
        chk(seen == 0, "R12 refresh holds off reset", seen, 0);
        wait_wdrst(60, n, w);
        chk(n <= 45, "R12 reset pulse on end", n, 40);
        chk(w == 1, "R12 pulse one clock", w, 1);
        chk(sq_out == s && irq == 0, "R12 no toggle or flag", int'({sq_out, irq}), int'({s, 1'b0}));
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk((v & 8) == 8, "R11 watchdog bit sticky", v & 8, 8);
        wait_wdrst(60, n, w);
        chk(n <= 45, "R11 runs with run bit clear", n, 40);
    endtask

    task automatic t_wdog_pin();
        int n, w;
        do_reset();
        wd_force = 1'b1;
        wr(3'd1, 8'h00);
        set_const(3);
        wr(3'd5, 8'h00);
        wait_wdrst(40, n, w);
        chk(n <= 20 && w == 1, "R11 pin forces watchdog", n, 16);
        wd_force = 1'b0;
        do_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_defaults();
        t_period(0, 0);
        t_period(2, 3);
        t_single();
        t_stop_resume();
        t_const_running();
        t_pre_now();
        t_event();
        t_irq();
        t_wdog_bit();
        t_wdog_pin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule